// File: doc/BRIEF.md
# Snooping Invalidate Cache Controller

This block controls a small direct-mapped, write-back cache. It stays coherent with its peers by watching a shared bus and invalidating its own copies when another agent writes. Each line holds one data word, a tag and one of three states. Invalid means the line holds nothing. Shared means the line is clean and may be read. Exclusive means the line is the only copy, may be written, and is dirty.

The processor side is a request port that is held until the stall output drops. Reads that hit Shared or Exclusive lines, and writes that hit Exclusive lines, complete with no bus traffic. Every other access becomes a bus transaction. The controller first requests the bus and waits for grant. It then writes back a dirty victim if there is one, and finally issues the read or write miss.

The snoop side sees the misses of the other caches. On a match it hands over dirty data and downgrades or invalidates the line within the same cycle.

Top module: `snoop_inv_cache`

## Requirements
- R1: After reset, all lines are Invalid, bus_req_o is low, and with no processor request the block raises neither stall nor bus request.
- R2: A read that hits a Shared or Exclusive line, or a write that hits an Exclusive line, completes without stall or bus activity. The read returns the line data in the same cycle, and the write updates the line at that edge.
- R3: A processor write to a line held Shared issues a write miss (bus_cmd_o = 2) and is never upgraded silently.
- R4: On a miss the block raises bus_req_o and places no command (bus_cmd_o = 0) until bus_gnt_i is high. With the grant held back for d cycles, the stall lasts d cycles longer than usual.
- R5: When the indexed line is Exclusive with a different tag, the block first issues a write-back (bus_cmd_o = 3) carrying the victim's address and data. The miss command follows in the next cycle after bus_ack_i.
- R6: A read miss (bus_cmd_o = 1) completes on bus_ack_i and fills the line as Shared with bus_rdata_i. A write miss completes on bus_ack_i and fills the line as Exclusive with the processor's write data.
- R7: A snooped read miss (snp_we_i = 0) that hits an Exclusive line raises snp_dirty_o with the line data on snp_data_o, and the line becomes Shared.
- R8: A snooped write miss (snp_we_i = 1) that hits a line moves it to Invalid. If the line was Exclusive, snp_dirty_o is raised with its data.
- R9: A snoop that misses (tag mismatch or Invalid line), or a snooped read of a Shared line, changes no state and keeps snp_dirty_o low.
- R10: cpu_stall_o stays high from a miss until the fill is done. It is also high in any cycle where a valid snoop has the same index as the processor request (index = low IDX_W address bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until stall is low |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid when stall is low |
| cpu_stall_o | output | 1 | Request not finished this cycle |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data from memory |
| bus_ack_i | input | 1 | Memory completes the current command |
| snp_valid_i | input | 1 | Another cache's miss is on the bus |
| snp_we_i | input | 1 | 1 = snooped write miss, 0 = snooped read miss |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_dirty_o | output | 1 | This cache supplies dirty data |
| snp_data_o | output | DATA_W | Dirty data handed over |

## Verification
The bench counts the stall cycles of every access exactly. A design that upgrades a Shared line silently, skips a needed write-back, or acts before grant gives a different count. A stale Shared line left valid after a snooped write would return old data where the golden memory holds the new value. A lost Exclusive-to-Shared downgrade would make a later write complete without a write miss. A dropped write-back on eviction shows up when the evicted address is read back. The same-index snoop-versus-hit collision is driven explicitly, and a design without that stall would complete a read from a line that was being invalidated.

// File: rtl/snic_pkg.sv
`timescale 1ns/1ps
package snic_pkg;
  typedef enum logic [1:0] {L_INV = 2'd0, L_SHR = 2'd1, L_EXC = 2'd2} line_st_e;
  typedef enum logic [1:0] {BC_IDLE = 2'd0, BC_RDMISS = 2'd1, BC_WRMISS = 2'd2, BC_WBACK = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {F_IDLE, F_ARB, F_WB, F_MISS} fsm_e;
endpackage

// File: rtl/snic_line_store.sv
`timescale 1ns/1ps
module snic_line_store
  import snic_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              fill_en_i,
  input  line_st_e          fill_st_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              snp_en_i,
  input  line_st_e          snp_st_i,
  input  logic              hit_wr_en_i,
  input  logic [DATA_W-1:0] hit_wr_data_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    wire a_sel = (a_idx_i == MY_IDX);
    wire b_sel = (b_idx_i == MY_IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 st_q[g] <= L_INV;
      else if (fill_en_i && a_sel) st_q[g] <= fill_st_i;
      else if (snp_en_i && b_sel)  st_q[g] <= snp_st_i;
    end

    always_ff @(posedge clk_i) begin
      if (fill_en_i && a_sel) begin
        tag_q[g]  <= fill_tag_i;
        data_q[g] <= fill_data_i;
      end else if (hit_wr_en_i && a_sel) begin
        data_q[g] <= hit_wr_data_i;
      end
    end
  end

  assign a_st_o   = st_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];
endmodule

// File: rtl/snic_snoop_unit.sv
`timescale 1ns/1ps
module snic_snoop_unit
  import snic_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              upd_en_o,
  output line_st_e          upd_st_o,
  output logic              dirty_o,
  output logic [DATA_W-1:0] data_o
);
  logic match;

  assign match    = snp_valid_i && (line_st_i != L_INV) && (line_tag_i == snp_tag_i);
  assign dirty_o  = match && (line_st_i == L_EXC);
  assign data_o   = line_data_i;
  // read snoop leaves Shared lines alone; anything else moves the line
  assign upd_en_o = match && (snp_we_i || line_st_i == L_EXC);
  assign upd_st_o = snp_we_i ? L_INV : L_SHR;
endmodule

// File: rtl/snic_miss_fsm.sv
`timescale 1ns/1ps
module snic_miss_fsm
  import snic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_req_i,
  input  logic                    cpu_we_i,
  input  logic [ADDR_W-1:0]       cpu_addr_i,
  input  logic [DATA_W-1:0]       cpu_wdata_i,
  input  line_st_e                line_st_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  logic [DATA_W-1:0]       line_data_i,
  output logic                    hit_o,
  input  logic                    bus_gnt_i,
  input  logic                    bus_ack_i,
  input  logic [DATA_W-1:0]       bus_rdata_i,
  output logic                    bus_req_o,
  output logic [1:0]              bus_cmd_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [DATA_W-1:0]       bus_wdata_o,
  output logic                    fill_en_o,
  output line_st_e                fill_st_o,
  output logic [DATA_W-1:0]       fill_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e st_q, st_d;
  logic [TAG_W-1:0] cpu_tag;
  logic [IDX_W-1:0] cpu_idx;
  logic tag_eq, victim_dirty;

  assign cpu_tag      = cpu_addr_i[ADDR_W-1:IDX_W];
  assign cpu_idx      = cpu_addr_i[IDX_W-1:0];
  assign tag_eq       = (line_tag_i == cpu_tag);
  // Shared + write is a miss: no silent upgrade
  assign hit_o        = (line_st_i != L_INV) && tag_eq && (!cpu_we_i || line_st_i == L_EXC);
  assign victim_dirty = (line_st_i == L_EXC) && !tag_eq;

  always_comb begin
    st_d        = st_q;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BC_IDLE;
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = line_data_i;
    fill_en_o   = 1'b0;
    fill_st_o   = cpu_we_i ? L_EXC : L_SHR;
    fill_data_o = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
    case (st_q)
      F_IDLE: if (cpu_req_i && !hit_o) st_d = F_ARB;
      F_ARB: begin
        bus_req_o = 1'b1;
        if (bus_gnt_i) st_d = victim_dirty ? F_WB : F_MISS;
      end
      F_WB: begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = BC_WBACK;
        bus_addr_o = {line_tag_i, cpu_idx};
        if (bus_ack_i) st_d = F_MISS;
      end
      F_MISS: begin
        bus_req_o = 1'b1;
        bus_cmd_o = cpu_we_i ? BC_WRMISS : BC_RDMISS;
        if (bus_ack_i) begin
          fill_en_o = 1'b1;
          st_d      = F_IDLE;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= F_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/snoop_inv_cache.sv
`timescale 1ns/1ps
module snoop_inv_cache
  import snic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_dirty_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  line_st_e          a_st, b_st, fill_st, snp_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data, fill_data;
  logic              fill_en, snp_en, hit, conflict, hit_wr_en;

  assign cpu_idx   = cpu_addr_i[IDX_W-1:0];
  assign snp_idx   = snp_addr_i[IDX_W-1:0];
  // snoop owns the line this cycle; processor retries next cycle
  assign conflict  = snp_valid_i && (snp_idx == cpu_idx);
  assign cpu_stall_o = cpu_req_i && (!hit || conflict);
  assign hit_wr_en = cpu_req_i && cpu_we_i && hit && !conflict;
  assign cpu_rdata_o = a_data;

  snic_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .a_idx_i(cpu_idx), .a_st_o(a_st), .a_tag_o(a_tag), .a_data_o(a_data),
    .b_idx_i(snp_idx), .b_st_o(b_st), .b_tag_o(b_tag), .b_data_o(b_data),
    .fill_en_i(fill_en), .fill_st_i(fill_st), .fill_tag_i(cpu_addr_i[ADDR_W-1:IDX_W]),
    .fill_data_i(fill_data),
    .snp_en_i(snp_en), .snp_st_i(snp_st),
    .hit_wr_en_i(hit_wr_en), .hit_wr_data_i(cpu_wdata_i)
  );

  snic_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid_i, .snp_we_i, .snp_tag_i(snp_addr_i[ADDR_W-1:IDX_W]),
    .line_st_i(b_st), .line_tag_i(b_tag), .line_data_i(b_data),
    .upd_en_o(snp_en), .upd_st_o(snp_st), .dirty_o(snp_dirty_o), .data_o(snp_data_o)
  );

  snic_miss_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .line_st_i(a_st), .line_tag_i(a_tag), .line_data_i(a_data),
    .hit_o(hit),
    .bus_gnt_i, .bus_ack_i, .bus_rdata_i,
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o,
    .fill_en_o(fill_en), .fill_st_o(fill_st), .fill_data_o(fill_data)
  );
endmodule

// File: rtl/snic_checker.sv
`timescale 1ns/1ps
module snic_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_stall_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i,
  input logic              snp_valid_i,
  input logic              snp_dirty_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_req_i && !bus_req_o) |=> !bus_req_o);

  p_cmd_after_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 2'd0) |-> (bus_req_o && bus_gnt_i));

  p_wb_victim_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 2'd3) |-> (bus_addr_o[IDX_W-1:0] == cpu_addr_i[IDX_W-1:0]
                             && bus_addr_o != cpu_addr_i));

  p_wb_then_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 2'd3 && bus_ack_i) |=> (bus_cmd_o == 2'd1 || bus_cmd_o == 2'd2));

  p_wr_fill_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == 2'd2 && bus_ack_i) |=> (!cpu_stall_o || snp_valid_i));

  p_dirty_on_snoop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_dirty_o |-> snp_valid_i);

  p_req_rise_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> cpu_stall_o);
endmodule

bind snoop_inv_cache snic_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i),
  .cpu_stall_o(cpu_stall_o), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_ack_i(bus_ack_i),
  .snp_valid_i(snp_valid_i), .snp_dirty_o(snp_dirty_o)
);

// File: tb/snoop_inv_cache_tb.sv
`timescale 1ns/1ps
module snoop_inv_cache_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NROW   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_ack = 0, snp_valid = 0, snp_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0, bus_rdata = '0;
  logic [DATA_W-1:0] cpu_rdata, bus_wdata, snp_data;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0] bus_cmd;
  logic cpu_stall, bus_req, snp_dirty;

  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] gold [256];
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  snoop_inv_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .cpu_stall_o(cpu_stall),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack),
    .snp_valid_i(snp_valid), .snp_we_i(snp_we), .snp_addr_i(snp_addr),
    .snp_dirty_o(snp_dirty), .snp_data_o(snp_data)
  );

  // {we, addr, wdata, expect_hit, expect_writeback}
  localparam logic [26:0] VEC [NROW] = '{
    {1'b0, 8'h10, 16'h0000, 1'b0, 1'b0},
    {1'b0, 8'h10, 16'h0000, 1'b1, 1'b0},
    {1'b1, 8'h10, 16'hAAAA, 1'b0, 1'b0},
    {1'b0, 8'h10, 16'h0000, 1'b1, 1'b0},
    {1'b1, 8'h10, 16'hBBBB, 1'b1, 1'b0},
    {1'b0, 8'h20, 16'h0000, 1'b0, 1'b1},
    {1'b0, 8'h10, 16'h0000, 1'b0, 1'b0},
    {1'b1, 8'h11, 16'h1234, 1'b0, 1'b0},
    {1'b0, 8'h11, 16'h0000, 1'b1, 1'b0},
    {1'b0, 8'h12, 16'h0000, 1'b0, 1'b0},
    {1'b1, 8'h21, 16'h5555, 1'b0, 1'b1},
    {1'b0, 8'h11, 16'h0000, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // processor access; this task also acts as arbiter and memory
  task automatic access(input logic we, input logic [7:0] addr, input logic [15:0] wd,
                        input int gnt_delay, output int stalls, output bit wb,
                        output bit rdm, output bit wrm, output logic [15:0] rd);
    int waited = 0;
    stalls = 0; wb = 0; rdm = 0; wrm = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    while (cpu_stall && stalls < 100) begin
      stalls++;
      bus_ack = 0;
      if (bus_req) begin
        if (waited >= gnt_delay) bus_gnt = 1;
        else waited++;
      end else bus_gnt = 0;
      if (bus_cmd == 2'd3) begin
        mem[bus_addr] = bus_wdata; wb = 1; bus_ack = 1;
      end else if (bus_cmd != 2'd0) begin
        bus_rdata = mem[bus_addr]; bus_ack = 1;
        if (bus_cmd == 2'd1) rdm = 1; else wrm = 1;
      end
      @(negedge clk); #1;
    end
    rd = cpu_rdata;
    bus_ack = 0;
    if (we) gold[addr] = wd;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; bus_gnt = 0;
  endtask

  task automatic snoop(input logic we, input logic [7:0] addr,
                       output bit dirty, output logic [15:0] data);
    @(negedge clk);
    snp_valid = 1; snp_we = we; snp_addr = addr;
    #1;
    dirty = snp_dirty; data = snp_data;
    if (dirty) mem[addr] = data;
    @(negedge clk);
    snp_valid = 0; snp_we = 0;
  endtask

  task automatic other_write(input logic [7:0] addr, input logic [15:0] v);
    mem[addr] = v; gold[addr] = v;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int st; bit wb, rdm, wrm, dty; logic [15:0] rd, sd;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 3 + 1); gold[i] = 16'(i * 3 + 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!cpu_stall, "R1", "stall idle", 32'(cpu_stall), 0);
    chk(!bus_req, "R1", "bus_req idle", 32'(bus_req), 0);
    snoop(1'b0, 8'h10, dty, sd);
    chk(!dty, "R1", "empty cache snoop dirty", 32'(dty), 0);

    for (int i = 0; i < NROW; i++) begin
      logic w; logic [7:0] a; logic [15:0] d; logic eh, ew; int exp_st;
      {w, a, d, eh, ew} = VEC[i];
      access(w, a, d, 0, st, wb, rdm, wrm, rd);
      exp_st = eh ? 0 : (ew ? 4 : 3);
      if (eh) chk(st == 0 && !wb && !rdm && !wrm, "R2", "hit stall/bus", 32'(st), 0);
      else chk(st == exp_st, ew ? "R5" : "R10", "miss stall cycles", 32'(st), 32'(exp_st));
      if (!eh) chk(wb == ew, "R5", "write-back issued", 32'(wb), 32'(ew));
      if (!eh && w) chk(wrm, "R3", "write miss cmd", 32'(wrm), 1);
      if (!eh && !w) chk(rdm, "R6", "read miss cmd", 32'(rdm), 1);
      if (!w) chk(rd == gold[a], "R6", "read data", 32'(rd), 32'(gold[a]));
    end

    // R7: snooped read of Exclusive line
    access(1'b1, 8'h13, 16'h7777, 0, st, wb, rdm, wrm, rd);
    snoop(1'b0, 8'h13, dty, sd);
    chk(dty && sd == 16'h7777, "R7", "dirty supply on read snoop", 32'(sd), 32'h7777);
    access(1'b0, 8'h13, 16'h0, 0, st, wb, rdm, wrm, rd);
    chk(st == 0 && rd == 16'h7777, "R7", "line Shared after read snoop", 32'(st), 0);
    access(1'b1, 8'h13, 16'h8888, 0, st, wb, rdm, wrm, rd);
    chk(wrm && st == 3, "R3", "write to downgraded line misses", 32'(st), 3);

    // R8: snooped write of Exclusive line
    snoop(1'b1, 8'h13, dty, sd);
    chk(dty && sd == 16'h8888, "R8", "dirty supply on write snoop", 32'(sd), 32'h8888);
    other_write(8'h13, 16'h9999);
    access(1'b0, 8'h13, 16'h0, 0, st, wb, rdm, wrm, rd);
    chk(st == 3 && rd == 16'h9999, "R8", "Exclusive invalidated", 32'(rd), 32'h9999);

    // R8: snooped write of Shared line
    snoop(1'b1, 8'h10, dty, sd);
    chk(!dty, "R8", "Shared line no dirty", 32'(dty), 0);
    other_write(8'h10, 16'h4242);
    access(1'b0, 8'h10, 16'h0, 0, st, wb, rdm, wrm, rd);
    chk(st == 3 && rd == 16'h4242, "R8", "Shared invalidated", 32'(rd), 32'h4242);

    // R9: tag mismatch and Shared read snoop have no effect
    snoop(1'b1, 8'h22, dty, sd);
    chk(!dty, "R9", "mismatch snoop dirty", 32'(dty), 0);
    access(1'b0, 8'h12, 16'h0, 0, st, wb, rdm, wrm, rd);
    chk(st == 0 && rd == gold[8'h12], "R9", "line kept after mismatch", 32'(st), 0);
    snoop(1'b0, 8'h11, dty, sd);
    access(1'b0, 8'h11, 16'h0, 0, st, wb, rdm, wrm, rd);
    chk(!dty && st == 0, "R9", "Shared read snoop no effect", 32'(st), 0);

    // R4: grant held back 5 cycles
    access(1'b0, 8'h23, 16'h0, 5, st, wb, rdm, wrm, rd);
    chk(st == 8, "R4", "stall with delayed grant", 32'(st), 8);
    chk(rd == gold[8'h23], "R4", "data after delayed grant", 32'(rd), 32'(gold[8'h23]));

    // R10: snoop and processor hit on same index
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h12;
    snp_valid = 1; snp_we = 1; snp_addr = 8'h12;
    #1;
    chk(cpu_stall, "R10", "stall on same-index snoop", 32'(cpu_stall), 1);
    @(negedge clk);
    cpu_req = 0; snp_valid = 0; snp_we = 0;
    other_write(8'h12, 16'h3131);
    access(1'b0, 8'h12, 16'h0, 0, st, wb, rdm, wrm, rd);
    chk(st == 3 && rd == 16'h3131, "R8", "invalidated under collision", 32'(rd), 32'h3131);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule